// File: doc/BRIEF.md
# Programmable Parallel Display Bus Timer

This block runs single accesses on an 8080-style parallel bus to an external display controller. A host raises one of three request lines: command write, data write or read. The block then drives an active-low chip select, write strobe and read strobe. Each strobe's edges sit at tick counts taken from two timing words. One tick is one clock or two clocks, chosen by a divide-select input. A command/data select line tells the controller whether a write carries a command (low) or data (high).

Writes drive the output data bus for the whole access. Reads capture the input bus on the tick whose count equals the programmed access time. The captured value stays on `rd_data` until the next read. The bus is 8 or 16 bits wide, chosen by a 2-bit mode input. A busy output holds off new requests. A host keeps its request raised until it is accepted, so requests made while busy wait rather than being lost.

The controller has three states. ST_IDLE accepts a request. ST_WRITE covers command and data writes. ST_READ covers reads. The transitions are:
- ACCEPT_WR goes from ST_IDLE to ST_WRITE on `cmd_req` or `dat_req`.
- ACCEPT_RD goes from ST_IDLE to ST_READ on `rd_req` when no write is requested.
- END_WR goes from ST_WRITE back to ST_IDLE on the tick where the count equals the write cycle time.
- END_RD goes from ST_READ back to ST_IDLE on the tick where the count equals the read cycle time.

Top module: `disp_bus_timer`

## Requirements
- R1: After reset, `busy` is 0, `bus_cs_n`, `bus_wr_n` and `bus_rd_n` are 1, and `bus_oe` is 0.
- R2: `tim_a` holds chip-select on [3:0] and off [9:4], write-strobe on [13:10] and off [19:14], read-strobe on [23:20] and off [29:24]. `tim_b` holds write cycle [5:0], read cycle [11:6] and access time [27:22]. Bits [17:12] of `tim_b` (pulse width) are accepted but unused.
- R3: Counting ticks from 0 at acceptance, a strobe is low while on <= count < off. The chip select applies to every access, the write strobe only to writes and the read strobe only to reads.
- R4: An access lasts cycle+1 ticks. Writes use the write cycle time and reads use the read cycle time. `busy` is 1 for exactly those ticks.
- R5: With `div2`=0 a tick is one clock; with `div2`=1 a tick is two clocks.
- R6: `bus_dc` is 0 for a command write and 1 for a data write, and stays constant for the access.
- R7: `width_mode`=3 selects 16-bit transfers. Any other value selects 8-bit transfers: the upper byte of `bus_dout` and of captured read data is 0.
- R8: A read latches `bus_din` on the last clock of the tick whose count equals the access time. `rd_data` then holds that value through later writes until the next read.
- R9: A request is accepted only while `busy` is 0. A held request is accepted on the clock after `busy` falls. Priority when requests coincide is command, then data, then read.
- R10: `bus_oe` is 1 throughout a write access and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tim_a | input | 32 | Strobe edge timing word |
| tim_b | input | 32 | Cycle and access timing word |
| div2 | input | 1 | 1: two clocks per tick |
| width_mode | input | 2 | 3: 16-bit, else 8-bit |
| cmd_req | input | 1 | Command write request (level) |
| cmd_data | input | 16 | Command word |
| dat_req | input | 1 | Data write request (level) |
| dat_data | input | 16 | Data word |
| rd_req | input | 1 | Read request (level) |
| busy | output | 1 | Access in progress |
| rd_data | output | 16 | Last captured read value |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | 0 command, 1 data |
| bus_oe | output | 1 | Output data bus enable |
| bus_dout | output | 16 | Output data bus |
| bus_din | input | 16 | Input data bus |

## Verification
The bench measures each strobe's first low clock and its low length at both divide settings, including strobes that open at tick 0. A design with an off-by-one window or a divider applied to only part of the logic shifts these numbers. Each access programs the unused cycle time and unused strobe to different values. A design that picks the wrong cycle field or fires the wrong strobe is therefore caught. The input bus is inverted just after the access-time tick, so a read that samples late returns the wrong value. Three requests raised together must be served command, data, read, with no access overlapping another.

// File: rtl/disp_bus_pkg.sv
package disp_bus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic [5:0] cs_on;
        logic [5:0] cs_off;
        logic [5:0] wr_on;
        logic [5:0] wr_off;
        logic [5:0] rd_on;
        logic [5:0] rd_off;
        logic [5:0] wcyc;
        logic [5:0] rcyc;
        logic [5:0] actim;
    } bus_timing_t;

    // Field positions are fixed by the programming model (R2).
    function automatic bus_timing_t unpack_timing(input logic [31:0] a, input logic [31:0] b);
        bus_timing_t t;
        t.cs_on  = {2'b00, a[3:0]};
        t.cs_off = a[9:4];
        t.wr_on  = {2'b00, a[13:10]};
        t.wr_off = a[19:14];
        t.rd_on  = {2'b00, a[23:20]};
        t.rd_off = a[29:24];
        t.wcyc   = b[5:0];
        t.rcyc   = b[11:6];
        t.actim  = b[27:22];
        return t;
    endfunction
endpackage

// File: rtl/dbt_tick_div.sv
module dbt_tick_div (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div2,
    output logic tick
);
    logic phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= 1'b0;
        else if (!run)
            phase <= 1'b0;
        else
            phase <= ~phase;
    end

    assign tick = run & (~div2 | phase);
endmodule

// File: rtl/dbt_window.sv
module dbt_window #(
    parameter int CW = 6
) (
    input  logic          en,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] t_on,
    input  logic [CW-1:0] t_off,
    output logic          act_n
);
    assign act_n = ~(en && (cnt >= t_on) && (cnt < t_off));
endmodule

// File: rtl/disp_bus_timer.sv
module disp_bus_timer
    import disp_bus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   tim_a,
    input  logic [31:0]   tim_b,
    input  logic          div2,
    input  logic [1:0]    width_mode,
    input  logic          cmd_req,
    input  logic [DW-1:0] cmd_data,
    input  logic          dat_req,
    input  logic [DW-1:0] dat_data,
    input  logic          rd_req,
    output logic          busy,
    output logic [DW-1:0] rd_data,
    output logic          bus_cs_n,
    output logic          bus_wr_n,
    output logic          bus_rd_n,
    output logic          bus_dc,
    output logic          bus_oe,
    output logic [DW-1:0] bus_dout,
    input  logic [DW-1:0] bus_din
);
    localparam int CW = 6;
    localparam int NW = DW / 2;
    localparam int NSTB = 3;

    bus_state_e    st, st_nx;
    bus_timing_t   tm;
    logic [CW-1:0] cnt;
    logic          tick;
    logic          wide;
    logic          accept;
    logic [DW-1:0] wr_q, rd_q;
    logic          dc_q;

    logic [NSTB-1:0]         stb_en, stb_n;
    logic [NSTB-1:0][CW-1:0] stb_on, stb_off;

    assign tm   = unpack_timing(tim_a, tim_b);
    assign wide = (width_mode == 2'b11);

    function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic w);
        return w ? v : {{(DW-NW){1'b0}}, v[NW-1:0]};
    endfunction

    dbt_tick_div u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st != ST_IDLE),
        .div2 (div2),
        .tick (tick)
    );

    // Next state: ACCEPT_WR, ACCEPT_RD, END_WR, END_RD
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (cmd_req || dat_req) st_nx = ST_WRITE;
                else if (rd_req)        st_nx = ST_READ;
            end
            ST_WRITE: if (tick && cnt == tm.wcyc) st_nx = ST_IDLE;
            ST_READ:  if (tick && cnt == tm.rcyc) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    assign accept = (st == ST_IDLE) && (cmd_req || dat_req || rd_req);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            wr_q <= '0;
            dc_q <= 1'b0;
            rd_q <= '0;
        end else begin
            if (st == ST_IDLE) begin
                cnt <= '0;
                if (accept && (cmd_req || dat_req)) begin
                    dc_q <= ~cmd_req;
                    wr_q <= fit(cmd_req ? cmd_data : dat_data, wide);
                end
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
            if (st == ST_READ && tick && cnt == tm.actim)
                rd_q <= fit(bus_din, wide);
        end
    end

    // Strobe windows: 0 = chip select, 1 = write, 2 = read
    assign stb_en  = {st == ST_READ, st == ST_WRITE, st != ST_IDLE};
    assign stb_on  = {tm.rd_on,  tm.wr_on,  tm.cs_on};
    assign stb_off = {tm.rd_off, tm.wr_off, tm.cs_off};

    for (genvar g = 0; g < NSTB; g++) begin : g_stb
        dbt_window #(.CW(CW)) u_win (
            .en   (stb_en[g]),
            .cnt  (cnt),
            .t_on (stb_on[g]),
            .t_off(stb_off[g]),
            .act_n(stb_n[g])
        );
    end

    always_comb begin
        busy     = (st != ST_IDLE);
        bus_oe   = (st == ST_WRITE);
        bus_dc   = dc_q;
        bus_dout = wr_q;
        rd_data  = rd_q;
        bus_cs_n = stb_n[0];
        bus_wr_n = stb_n[1];
        bus_rd_n = stb_n[2];
    end
endmodule

// File: rtl/disp_bus_timer_chk.sv
module disp_bus_timer_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic [DW-1:0] rd_data,
    input logic          bus_cs_n,
    input logic          bus_wr_n,
    input logic          bus_rd_n,
    input logic          bus_dc,
    input logic          bus_oe,
    input logic [DW-1:0] bus_dout
);
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_cs_n && bus_wr_n && bus_rd_n));

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_wr_n && !bus_rd_n));

    assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n);

    assert_oe_write_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (busy && bus_rd_n));

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rd_data));

    assert_dc_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bus_dc));

    assert_dout_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bus_dout));
endmodule

bind disp_bus_timer disp_bus_timer_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .rd_data (rd_data),
    .bus_cs_n(bus_cs_n),
    .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n),
    .bus_dc  (bus_dc),
    .bus_oe  (bus_oe),
    .bus_dout(bus_dout)
);

// File: tb/disp_bus_timer_bench.sv
module disp_bus_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    typedef struct packed {
        logic [1:0]  kind;   // 0 command, 1 data, 2 read
        logic        dv;
        logic [1:0]  mode;
        logic [15:0] data;
        logic [15:0] din;
        logic [5:0]  cs_on, cs_off, st_on, st_off, cyc, actim;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 2'd3, 16'hA5C3, 16'h0000, 6'd1, 6'd8, 6'd2, 6'd6, 6'd9,  6'd5},
        '{2'd1, 1'b1, 2'd0, 16'h12F0, 16'h0000, 6'd0, 6'd5, 6'd1, 6'd4, 6'd6,  6'd2},
        '{2'd2, 1'b0, 2'd3, 16'h0000, 16'hBEEF, 6'd1, 6'd9, 6'd2, 6'd8, 6'd10, 6'd6},
        '{2'd2, 1'b1, 2'd0, 16'h0000, 16'h7E81, 6'd0, 6'd4, 6'd1, 6'd3, 6'd5,  6'd2},
        '{2'd0, 1'b0, 2'd3, 16'hFFFF, 16'h0000, 6'd0, 6'd3, 6'd0, 6'd2, 6'd3,  6'd2},
        '{2'd1, 1'b0, 2'd1, 16'hABCD, 16'h0000, 6'd2, 6'd7, 6'd3, 6'd5, 6'd7,  6'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tim_a = '0, tim_b = '0;
    logic        div2 = 1'b0;
    logic [1:0]  width_mode = 2'd3;
    logic        cmd_req = 1'b0, dat_req = 1'b0, rd_req = 1'b0;
    logic [15:0] cmd_data = '0, dat_data = '0, bus_din = '0;
    logic        busy, bus_cs_n, bus_wr_n, bus_rd_n, bus_dc, bus_oe;
    logic [15:0] rd_data, bus_dout;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_bus_timer u_disp_bus_timer (
        .clk(clk), .rst_n(rst_n), .tim_a(tim_a), .tim_b(tim_b), .div2(div2),
        .width_mode(width_mode), .cmd_req(cmd_req), .cmd_data(cmd_data),
        .dat_req(dat_req), .dat_data(dat_data), .rd_req(rd_req), .busy(busy),
        .rd_data(rd_data), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_rd_n(bus_rd_n), .bus_dc(bus_dc), .bus_oe(bus_oe),
        .bus_dout(bus_dout), .bus_din(bus_din)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    function automatic logic [31:0] pack_a(input int cs_on, cs_off, we_on, we_off, re_on, re_off);
        return {2'b00, 6'(re_off), 4'(re_on), 6'(we_off), 4'(we_on), 6'(cs_off), 4'(cs_on)};
    endfunction

    function automatic logic [31:0] pack_b(input int wcyc, rcyc, actim);
        return {4'b0000, 6'(actim), 4'b0000, 6'd7, 6'(rcyc), 6'(wcyc)};
    endfunction

    function automatic logic [15:0] fit(input logic [15:0] v, input logic [1:0] m);
        return (m == 2'd3) ? v : {8'h00, v[7:0]};
    endfunction

    // Runs one access from a vector and measures the strobes at the ports.
    task automatic run_vec(input vec_t v);
        int d, i, cs_cnt, cs_first, st_cnt, st_first, oth_cnt, dc_bad, do_bad, oe_bad, cyc_end, st_end;
        logic [15:0] exp_rd;
        bit is_rd;
        is_rd = (v.kind == 2'd2);
        d = v.dv ? 2 : 1;
        @(negedge clk);
        div2 = v.dv;
        width_mode = v.mode;
        if (is_rd) begin
            tim_a = pack_a(v.cs_on, v.cs_off, 1, 3, v.st_on, v.st_off);
            tim_b = pack_b(v.cyc + 4, v.cyc, v.actim);
        end else begin
            tim_a = pack_a(v.cs_on, v.cs_off, v.st_on, v.st_off, 1, 3);
            tim_b = pack_b(v.cyc, v.cyc + 4, v.actim);
        end
        bus_din = v.din;
        cmd_data = v.data;
        dat_data = ~v.data;
        if (v.kind == 2'd1) dat_data = v.data;
        cmd_req = (v.kind == 2'd0);
        dat_req = (v.kind == 2'd1);
        rd_req  = is_rd;
        @(negedge clk);
        cmd_req = 0; dat_req = 0; rd_req = 0;
        i = 0; cs_cnt = 0; cs_first = -1; st_cnt = 0; st_first = -1;
        oth_cnt = 0; dc_bad = 0; do_bad = 0; oe_bad = 0;
        while (busy && i < 400) begin
            if (!bus_cs_n) begin cs_cnt++; if (cs_first < 0) cs_first = i; end
            if (is_rd ? !bus_rd_n : !bus_wr_n) begin st_cnt++; if (st_first < 0) st_first = i; end
            if (is_rd ? !bus_wr_n : !bus_rd_n) oth_cnt++;
            if (!is_rd && bus_dc !== (v.kind == 2'd1)) dc_bad++;
            if (!is_rd && bus_dout !== fit(v.data, v.mode)) do_bad++;
            if (bus_oe !== !is_rd) oe_bad++;
            if (is_rd && i == (int'(v.actim) + 1) * d) bus_din = ~v.din;
            @(negedge clk);
            i++;
        end
        cyc_end = int'(v.cyc) + 1;
        st_end = (int'(v.st_off) < cyc_end) ? int'(v.st_off) : cyc_end;
        chk("R4", "busy clocks", i, cyc_end * d);
        chk("R5", "chip select first clock", cs_first, int'(v.cs_on) * d);
        chk("R3", "chip select low clocks", cs_cnt,
            (((int'(v.cs_off) < cyc_end) ? int'(v.cs_off) : cyc_end) - int'(v.cs_on)) * d);
        chk("R3", "strobe first clock", st_first, int'(v.st_on) * d);
        chk("R3", "strobe low clocks", st_cnt, (st_end - int'(v.st_on)) * d);
        chk("R3", "wrong strobe low clocks", oth_cnt, 0);
        chk("R10", "bus_oe mismatched clocks", oe_bad, 0);
        if (is_rd) begin
            exp_rd = fit(v.din, v.mode);
            chk("R8", "read capture", int'(rd_data), int'(exp_rd));
        end else begin
            chk("R6", "bus_dc mismatched clocks", dc_bad, 0);
            chk("R7", "bus_dout mismatched clocks", do_bad, 0);
        end
    endtask

    initial begin
        int seq_bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "strobes", int'({bus_cs_n, bus_wr_n, bus_rd_n}), 7);
        chk("R1", "bus_oe", int'(bus_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after release", int'({busy, bus_cs_n, bus_wr_n, bus_rd_n}), 7);

        // R2 R3 R4 R5 R6 R7 R8 R10: vector table
        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R8: rd_data holds through writes with a different input bus
        begin
            vec_t w;
            w = VEC[0];
            w.din = 16'h0F0F;
            run_vec(w);
            chk("R8", "rd_data unchanged by write", int'(rd_data), int'(16'h0081));
        end

        // R9: priority and stalling of held requests
        @(negedge clk);
        div2 = 0; width_mode = 2'd3;
        tim_a = pack_a(0, 4, 1, 3, 1, 3);
        tim_b = pack_b(4, 4, 2);
        cmd_data = 16'h1111; dat_data = 16'h2222; bus_din = 16'h3C3C;
        cmd_req = 1; dat_req = 1; rd_req = 1;
        @(negedge clk);
        chk("R9", "command first", int'({busy, bus_oe, bus_dc}), 6);
        chk("R9", "command word", int'(bus_dout), int'(16'h1111));
        cmd_req = 0;
        seq_bad = 0;
        while (busy) begin
            if (!bus_rd_n) seq_bad++;
            @(negedge clk);
        end
        chk("R9", "held read not started during write", seq_bad, 0);
        @(negedge clk);
        chk("R9", "data second", int'({busy, bus_oe, bus_dc}), 7);
        chk("R9", "data word", int'(bus_dout), int'(16'h2222));
        dat_req = 0;
        while (busy) @(negedge clk);
        chk("R9", "idle gap after access", int'(busy), 0);
        @(negedge clk);
        chk("R9", "read third", int'({busy, bus_oe}), 2);
        rd_req = 0;
        while (busy) @(negedge clk);
        chk("R9", "read result", int'(rd_data), int'(16'h3C3C));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule